// File: doc/BRIEF.md
# Dual-Edge Video Input Capture

This block sits at the input of a digital display transmitter. It samples a parallel pixel bus together with a data-enable line, horizontal and vertical sync and a 3-bit control field. Once per pixel period it presents one rebuilt 24-bit pixel word. Each word is tagged as either active video or blanking control.

Two bus modes are supported. In full-width mode all 24 bits arrive on a single clock edge. In half-width mode 12 bits arrive on each of the two clock edges and are joined into one pixel. The primary latching edge can be rising or falling.

The bus mode and the primary edge come from one of two sources, picked by a select input. One source is a pair of strap inputs. The other is a small configuration register pair written on the rising clock edge. Dropping the select input and raising it again puts the registers back to their defaults.

Top module: `pixcap_top`

## Requirements
- R1: With the full-bus setting at 1, the whole 24-bit `bus_pix` is sampled on the primary edge. Whatever the bus carries on the other edge has no effect on the output.
- R2: With the full-bus setting at 0, `bus_pix[11:0]` is sampled on the primary edge and becomes output bits [11:0]. `bus_pix[11:0]` on the next opposite edge becomes output bits [23:12]. `bus_pix[23:12]` is ignored, and data enable, syncs and control are sampled on the primary edge only.
- R3: With the rising-edge setting at 1 the primary edge is the rising clock edge. With it at 0 the primary edge is the falling edge, and the outputs change only just after primary edges.
- R4: Consider a word whose primary-edge sample is taken at primary edge k. With the configuration stable, that word appears on the outputs just after primary edge k+2 with `out_valid` = 1.
- R5: A word sampled with data enable high gives `out_active` = 1 and `pix_out` = the pixel. `out_hsync`, `out_vsync` and `out_ctl` are all 0 for such a word.
- R6: A word sampled with data enable low gives `out_active` = 0 and `pix_out` = 0. `out_hsync`, `out_vsync` and `out_ctl` carry the values sampled on the primary edge.
- R7: With `src_reg_sel` = 0 the configuration comes from `strap_full_bus`/`strap_rise_edge`. With `src_reg_sel` = 1 it comes from the configuration registers.
- R8: The configuration registers are loaded from `cfg_full_bus`/`cfg_rise_edge` on a rising edge where `cfg_we` = 1, while `src_reg_sel` = 1. Their default is full-bus = 1 and rising-edge = 1. While `src_reg_sel` = 0 they are held at the default and writes are ignored, so a low-then-high pulse restores the default.
- R9: Let e be the first primary edge after any configuration change. The output words presented just after edges e and e+1 have `out_valid` = 0, and the word after e+2 is valid again.
- R10: While `rst_n` is low all outputs are 0. After release, the first two primary edges present invalid words. The third presents the word sampled at the first primary edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cap | input | 1 | Single-ended capture clock, both edges used |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_reg_sel | input | 1 | 0: strap configuration, 1: register configuration; low pulse resets registers |
| strap_full_bus | input | 1 | Strap: 1 full-width single-edge, 0 half-width dual-edge |
| strap_rise_edge | input | 1 | Strap: 1 rising primary edge, 0 falling |
| cfg_we | input | 1 | Register write strobe (rising edge) |
| cfg_full_bus | input | 1 | Register write value for bus mode |
| cfg_rise_edge | input | 1 | Register write value for primary edge |
| bus_pix | input | 24 | Pixel bus (lower 12 bits used in half-width mode) |
| bus_de | input | 1 | Data enable |
| bus_hsync | input | 1 | Horizontal sync |
| bus_vsync | input | 1 | Vertical sync |
| bus_ctl | input | 3 | Control field sent during blanking |
| pix_out | output | 24 | Rebuilt pixel, 0 during blanking |
| out_active | output | 1 | 1 active video, 0 blanking |
| out_hsync | output | 1 | Sync for blanking words, 0 for active words |
| out_vsync | output | 1 | Sync for blanking words, 0 for active words |
| out_ctl | output | 3 | Control for blanking words, 0 for active words |
| out_valid | output | 1 | Word is a complete pixel period under a settled configuration |

## Verification
A stale or wrongly selected half register shows up as swapped or inverted 12-bit halves in `pix_out`. This appears on the second primary edge after the affected sample, so streams with distinct upper and lower halves, and garbage on the ignored pins and edges, expose it within one pixel period. A bad applied-configuration or start-up state appears as an `out_valid` pattern that differs from the exact two-word gap after a change or reset. A wrong register default appears as mangled pixels in the very next stream after the select input is pulsed.

// File: rtl/pixcap_pkg.sv
`timescale 1ns/1ps
package pixcap_pkg;
    localparam int HALF_W = 12;
    localparam int PIX_W  = 2 * HALF_W;
    localparam int CTL_W  = 3;
    localparam int N_EDGE = 2;

    typedef struct packed {
        logic full_bus;
        logic rise_edge;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{full_bus: 1'b1, rise_edge: 1'b1};

    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic             de;
        logic             hs;
        logic             vs;
        logic [CTL_W-1:0] ctl;
    } samp_t;

    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic             act;
        logic             hs;
        logic             vs;
        logic [CTL_W-1:0] ctl;
        logic             valid;
    } word_t;
endpackage

// File: rtl/pixcap_cfg.sv
`timescale 1ns/1ps
module pixcap_cfg
    import pixcap_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic src_reg_i,
    input  cfg_t strap_i,
    input  logic we_i,
    input  cfg_t wdata_i,
    output cfg_t cfg_o
);
    typedef struct packed {
        cfg_t regs;
    } cfg_st_t;

    localparam cfg_st_t ST_RESET = '{regs: CFG_DEFAULT};

    cfg_st_t st_d, st_q;
    logic    reg_rst_n;

    // Register file is held in reset whenever the register source is deselected.
    assign reg_rst_n = rst_ni & src_reg_i;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.regs = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge reg_rst_n) begin
        if (!reg_rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = src_reg_i ? st_q.regs : strap_i;

    // Registers are back at their default when the register source is re-selected.
    assert_regs_default_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(src_reg_i) |-> (st_q.regs == CFG_DEFAULT))
        else $error("R8: registers not restored to default");
endmodule

// File: rtl/pixcap_capture.sv
`timescale 1ns/1ps
module pixcap_capture
    import pixcap_pkg::*;
#(
    parameter bit RISING = 1'b1
)(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  samp_t bus_i,
    output samp_t samp_o
);
    logic  edge_clk;
    samp_t samp_d, samp_q;

    assign edge_clk = RISING ? clk_i : ~clk_i;

    always_comb begin
        samp_d = bus_i;
    end

    always_ff @(posedge edge_clk or negedge rst_ni) begin
        if (!rst_ni) begin
            samp_q <= '0;
        end else begin
            samp_q <= samp_d;
        end
    end

    assign samp_o = samp_q;
endmodule

// File: rtl/pixcap_lane.sv
`timescale 1ns/1ps
module pixcap_lane
    import pixcap_pkg::*;
#(
    parameter bit RISING = 1'b1
)(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  cfg_t              cfg_i,
    input  samp_t             prim_i,
    input  logic [HALF_W-1:0] sec_half_i,
    output word_t             word_o
);
    localparam logic MY_EDGE = RISING;

    typedef struct packed {
        cfg_t  last_cfg;
        logic  seen;
        word_t b;
        word_t o;
    } lane_st_t;

    localparam lane_st_t ST_RESET = '{last_cfg: CFG_DEFAULT, seen: 1'b0, b: '0, o: '0};

    logic             lane_clk;
    lane_st_t         st_d, st_q;
    logic [PIX_W-1:0] joined;
    logic             cfg_same;
    logic             is_primary;

    assign lane_clk = RISING ? clk_i : ~clk_i;

    always_comb begin
        is_primary = (cfg_i.rise_edge == MY_EDGE);
        cfg_same   = (cfg_i == st_q.last_cfg);
        joined     = cfg_i.full_bus ? prim_i.pix
                                    : {sec_half_i, prim_i.pix[HALF_W-1:0]};

        st_d          = st_q;
        st_d.last_cfg = cfg_i;
        st_d.seen     = 1'b1;

        // Stage B: assemble and tag the word sampled on the previous primary edge.
        st_d.b.act   = prim_i.de;
        st_d.b.pix   = prim_i.de ? joined : '0;
        st_d.b.hs    = prim_i.de ? 1'b0 : prim_i.hs;
        st_d.b.vs    = prim_i.de ? 1'b0 : prim_i.vs;
        st_d.b.ctl   = prim_i.de ? '0 : prim_i.ctl;
        st_d.b.valid = st_q.seen && cfg_same && is_primary;

        // Stage O: output register, invalidated again if the setting moved.
        st_d.o       = st_q.b;
        st_d.o.valid = st_q.b.valid && cfg_same && is_primary;
    end

    always_ff @(posedge lane_clk or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.o;

    // Half-width join: primary half low, opposite-edge half high.
    assert_dual_join_R2: assert property (@(posedge lane_clk) disable iff (!rst_ni)
        (prim_i.de && !cfg_i.full_bus) |=>
        (st_q.b.pix == {$past(sec_half_i), $past(prim_i.pix[HALF_W-1:0])}))
        else $error("R2: halves joined wrongly");

    assert_active_clear_R5: assert property (@(posedge lane_clk) disable iff (!rst_ni)
        prim_i.de |=> (st_q.b.act && !st_q.b.hs && !st_q.b.vs && (st_q.b.ctl == '0)))
        else $error("R5: active word carries control");

    assert_blank_ctl_R6: assert property (@(posedge lane_clk) disable iff (!rst_ni)
        !prim_i.de |=> (!st_q.b.act && (st_q.b.pix == '0) &&
                        (st_q.b.ctl == $past(prim_i.ctl)) &&
                        (st_q.b.hs == $past(prim_i.hs)) && (st_q.b.vs == $past(prim_i.vs))))
        else $error("R6: blanking word wrong");

    assert_change_gap_R9: assert property (@(posedge lane_clk) disable iff (!rst_ni)
        (cfg_i != st_q.last_cfg) |=> (!st_q.o.valid ##1 !st_q.o.valid))
        else $error("R9: valid word too soon after change");
endmodule

// File: rtl/pixcap_top.sv
`timescale 1ns/1ps
module pixcap_top
    import pixcap_pkg::*;
(
    input  logic             clk_cap,
    input  logic             rst_n,
    input  logic             src_reg_sel,
    input  logic             strap_full_bus,
    input  logic             strap_rise_edge,
    input  logic             cfg_we,
    input  logic             cfg_full_bus,
    input  logic             cfg_rise_edge,
    input  logic [PIX_W-1:0] bus_pix,
    input  logic             bus_de,
    input  logic             bus_hsync,
    input  logic             bus_vsync,
    input  logic [CTL_W-1:0] bus_ctl,
    output logic [PIX_W-1:0] pix_out,
    output logic             out_active,
    output logic             out_hsync,
    output logic             out_vsync,
    output logic [CTL_W-1:0] out_ctl,
    output logic             out_valid
);
    cfg_t  strap_cfg, wr_cfg, cfg_eff;
    samp_t bus_s;
    samp_t cap_s  [N_EDGE];
    word_t lane_w [N_EDGE];
    word_t sel_w;

    assign strap_cfg = '{full_bus: strap_full_bus, rise_edge: strap_rise_edge};
    assign wr_cfg    = '{full_bus: cfg_full_bus,   rise_edge: cfg_rise_edge};
    assign bus_s     = '{pix: bus_pix, de: bus_de, hs: bus_hsync, vs: bus_vsync, ctl: bus_ctl};

    pixcap_cfg i_cfg (
        .clk_i     (clk_cap),
        .rst_ni    (rst_n),
        .src_reg_i (src_reg_sel),
        .strap_i   (strap_cfg),
        .we_i      (cfg_we),
        .wdata_i   (wr_cfg),
        .cfg_o     (cfg_eff)
    );

    // Index 0 works on the rising edge, index 1 on the falling edge.
    for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
        pixcap_capture #(.RISING(g == 0)) i_cap (
            .clk_i  (clk_cap),
            .rst_ni (rst_n),
            .bus_i  (bus_s),
            .samp_o (cap_s[g])
        );

        pixcap_lane #(.RISING(g == 0)) i_lane (
            .clk_i      (clk_cap),
            .rst_ni     (rst_n),
            .cfg_i      (cfg_eff),
            .prim_i     (cap_s[g]),
            .sec_half_i (cap_s[N_EDGE-1-g].pix[HALF_W-1:0]),
            .word_o     (lane_w[g])
        );
    end

    always_comb begin
        sel_w = cfg_eff.rise_edge ? lane_w[0] : lane_w[1];
    end

    assign pix_out    = sel_w.pix;
    assign out_active = sel_w.act;
    assign out_hsync  = sel_w.hs;
    assign out_vsync  = sel_w.vs;
    assign out_ctl    = sel_w.ctl;
    assign out_valid  = sel_w.valid;

    assert_reset_quiet_R10: assert property (@(posedge clk_cap)
        !rst_n |-> (!out_valid && (pix_out == '0) && !out_active))
        else $error("R10: outputs not cleared in reset");
endmodule

// File: tb/test_pixcap_top.sv
`timescale 1ns/1ps
module test_pixcap_top;
    logic        clk_cap = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_reg_sel = 1'b0;
    logic        strap_full_bus = 1'b1;
    logic        strap_rise_edge = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_full_bus = 1'b0;
    logic        cfg_rise_edge = 1'b0;
    logic [23:0] bus_pix = '0;
    logic        bus_de = 1'b0;
    logic        bus_hsync = 1'b0;
    logic        bus_vsync = 1'b0;
    logic [2:0]  bus_ctl = '0;
    logic [23:0] pix_out;
    logic        out_active, out_hsync, out_vsync, out_valid;
    logic [2:0]  out_ctl;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    bit  mdl_full = 1'b1;
    bit  mdl_rise = 1'b1;

    always #2.5 clk_cap = ~clk_cap;

    pixcap_top i_pixcap_top (
        .clk_cap(clk_cap), .rst_n(rst_n), .src_reg_sel(src_reg_sel),
        .strap_full_bus(strap_full_bus), .strap_rise_edge(strap_rise_edge),
        .cfg_we(cfg_we), .cfg_full_bus(cfg_full_bus), .cfg_rise_edge(cfg_rise_edge),
        .bus_pix(bus_pix), .bus_de(bus_de), .bus_hsync(bus_hsync), .bus_vsync(bus_vsync),
        .bus_ctl(bus_ctl), .pix_out(pix_out), .out_active(out_active), .out_hsync(out_hsync),
        .out_vsync(out_vsync), .out_ctl(out_ctl), .out_valid(out_valid)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic prim_edge();
        if (mdl_rise) @(posedge clk_cap); else @(negedge clk_cap);
    endtask

    task automatic sec_edge();
        if (mdl_rise) @(negedge clk_cap); else @(posedge clk_cap);
    endtask

    function automatic logic [23:0] gen_pix(input int s, input int i);
        return 24'(s * 935 + i * 127699) ^ 24'h5A0F96;
    endfunction

    task automatic check_out(input string req, input logic [23:0] p, input logic de,
                             input logic hs, input logic vs, input logic [2:0] ctl);
        chk("R4", "valid", 32'(out_valid), 32'd1);
        chk(de ? "R5" : "R6", "active", 32'(out_active), 32'(de));
        chk(req, "pixel", 32'(pix_out), de ? 32'(p) : 32'd0);
        chk(de ? "R5" : "R6", "hsync", 32'(out_hsync), de ? 32'd0 : 32'(hs));
        chk(de ? "R5" : "R6", "vsync", 32'(out_vsync), de ? 32'd0 : 32'(vs));
        chk(de ? "R5" : "R6", "ctl", 32'(out_ctl), de ? 32'd0 : 32'(ctl));
    endtask

    // Streams n words in the modelled mode; garbage sits on ignored pins and edges.
    task automatic run_stream(input string req, input int n, input int seed);
        logic [23:0] e_pix [40];
        logic        e_de  [40];
        logic        e_hs  [40];
        logic        e_vs  [40];
        logic [2:0]  e_ctl [40];
        repeat (4) prim_edge();
        for (int i = 0; i < n; i++) begin
            logic [23:0] w;
            w        = gen_pix(seed, i);
            e_pix[i] = w;
            e_de[i]  = (i % 4) != 3;
            e_hs[i]  = (i & 1) != 0;
            e_vs[i]  = (i & 2) != 0;
            e_ctl[i] = 3'(i >> 2) ^ 3'(seed);
            sec_edge(); #1;
            bus_pix   = mdl_full ? w : {~w[23:12], w[11:0]};
            bus_de    = e_de[i];
            bus_hsync = e_hs[i];
            bus_vsync = e_vs[i];
            bus_ctl   = e_ctl[i];
            prim_edge(); #1;
            if (i >= 2) check_out(req, e_pix[i-2], e_de[i-2], e_hs[i-2], e_vs[i-2], e_ctl[i-2]);
            bus_pix   = mdl_full ? ~w : {~w[11:0], w[23:12]};
            bus_de    = ~bus_de;
            bus_hsync = ~bus_hsync;
            bus_vsync = ~bus_vsync;
            bus_ctl   = ~bus_ctl;
        end
    endtask

    task automatic reg_write(input logic full, input logic rise);
        @(negedge clk_cap); #1;
        cfg_we = 1'b1; cfg_full_bus = full; cfg_rise_edge = rise;
        @(posedge clk_cap); #1;
        cfg_we = 1'b0;
    endtask

    task automatic test_reset();
        repeat (3) @(posedge clk_cap);
        #1;
        chk("R10", "pix in reset", 32'(pix_out), 32'd0);
        chk("R10", "valid in reset", 32'(out_valid), 32'd0);
        @(negedge clk_cap); #1;
        rst_n = 1'b1;
        bus_pix = 24'h123456; bus_de = 1'b1;
        @(posedge clk_cap); #1;
        chk("R10", "valid edge1", 32'(out_valid), 32'd0);
        bus_pix = 24'hFEDCBA;
        @(posedge clk_cap); #1;
        chk("R10", "valid edge2", 32'(out_valid), 32'd0);
        @(posedge clk_cap); #1;
        chk("R10", "valid edge3", 32'(out_valid), 32'd1);
        chk("R10", "first word", 32'(pix_out), 32'h123456);
    endtask

    task automatic test_wide_rise();
        strap_full_bus = 1'b1; strap_rise_edge = 1'b1; mdl_full = 1'b1; mdl_rise = 1'b1;
        run_stream("R1", 20, 1);
    endtask

    task automatic test_dual_rise();
        strap_full_bus = 1'b0; mdl_full = 1'b0;
        run_stream("R2", 20, 2);
    endtask

    task automatic test_fall();
        strap_rise_edge = 1'b0; strap_full_bus = 1'b1; mdl_rise = 1'b0; mdl_full = 1'b1;
        run_stream("R3", 16, 3);
        strap_full_bus = 1'b0; mdl_full = 1'b0;
        run_stream("R3", 16, 4);
    endtask

    task automatic test_reg_source();
        strap_full_bus = 1'b1; strap_rise_edge = 1'b1;
        src_reg_sel = 1'b1; mdl_full = 1'b1; mdl_rise = 1'b1;
        reg_write(1'b0, 1'b0);
        mdl_full = 1'b0; mdl_rise = 1'b0;
        run_stream("R7", 16, 5);
    endtask

    task automatic test_change_invalid();
        reg_write(1'b1, 1'b1);
        mdl_full = 1'b1; mdl_rise = 1'b1;
        run_stream("R9", 10, 6);
        @(negedge clk_cap); #1;
        cfg_we = 1'b1; cfg_full_bus = 1'b0; cfg_rise_edge = 1'b1;
        @(posedge clk_cap); #1;
        cfg_we = 1'b0;
        chk("R9", "valid before change", 32'(out_valid), 32'd1);
        @(posedge clk_cap); #1;
        chk("R9", "valid word1", 32'(out_valid), 32'd0);
        @(posedge clk_cap); #1;
        chk("R9", "valid word2", 32'(out_valid), 32'd0);
        @(posedge clk_cap); #1;
        chk("R9", "valid word3", 32'(out_valid), 32'd1);
        mdl_full = 1'b0;
        run_stream("R9", 10, 7);
    endtask

    task automatic test_defaults();
        src_reg_sel = 1'b0;
        strap_full_bus = 1'b0; strap_rise_edge = 1'b0;
        mdl_full = 1'b0; mdl_rise = 1'b0;
        reg_write(1'b0, 1'b0);
        run_stream("R7", 8, 8);
        src_reg_sel = 1'b1;
        mdl_full = 1'b1; mdl_rise = 1'b1;
        run_stream("R8", 16, 9);
    endtask

    initial begin
        repeat (60000) @(posedge clk_cap);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_wide_rise();
        test_dual_rise();
        test_fall();
        test_reg_source();
        test_change_invalid();
        test_defaults();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule